// File: doc/BRIEF.md
# Three-Bank Interrupt Cause Controller

This block gathers interrupt events from three hardware sources (receive, transmit and miscellaneous) into three 32-bit cause banks. Each bank has its own mask. Software raises or removes mask bits through separate set and clear registers, so a write to one never disturbs the others. A per-bit clear-mode register decides how each cause bit is cleared: by writing a one back (write-one-to-clear), or by the act of reading the cause register (clear-on-read). Software can also raise cause bits itself through a cause-set register, for example to run a handshake flag between agents.

Above the banks sits a three-bit summary cause register. It has one sticky bit per bank, and that bit is set while the bank holds any unmasked cause. Reading the summary register clears it. The summary has its own mask, and a single level interrupt output is high while any unmasked summary bit is set. An interrupt handler reads the summary, works through the banks it names, and then reads the summary again to release it.

Top module: `irq_cause_ctrl`

## Requirements
- R1: A bit that is high on an event input for one cycle sets the matching cause bit at that clock edge, and the bit stays set until software clears it. When an event and a software clear hit the same bit in the same cycle, the bit stays set.
- R2: A write to the mask-set register (register 1) sets every mask bit that is 1 in the data. A write to the mask-clear register (register 2) clears every mask bit that is 1 in the data. Mask bits written with 0 do not change. The mask reads back at register 6.
- R3: Register 5 reads the cause register AND NOT the mask.
- R4: A write to the cause register (register 0) clears those bits that are 1 in the data and whose clear-mode bit is 0. A bit in clear-on-read mode is not cleared by a write.
- R5: The clear-mode register (register 4, read/write) selects clear-on-read for every bit that is 1. A read of the cause register returns its value and clears the returned bits that are in clear-on-read mode. Bits in write-one-to-clear mode are left as they were.
- R6: A write to the cause-set register (register 3) sets every cause bit that is 1 in the data.
- R7: Summary bit 0 (receive), bit 1 (transmit) and bit 2 (miscellaneous) is set at the clock edge after its bank holds any unmasked cause. The bit then holds. A read of the summary register (address 0x18) returns it and clears it, unless the bank is still pending.
- R8: The summary mask (address 0x19, bits 2:0, 1 = masked) is readable and writable. The output irq_out is high exactly while some summary bit is set and unmasked, and it rises two clock edges after the event edge when the path is unmasked.
- R9: After reset, every cause bit is 0, every bank mask and every summary mask bit is 1, every clear-mode bit is 0 and irq_out is low.
- R10: The address is split into a bank field addr[4:3] (0 receive, 1 transmit, 2 miscellaneous, 3 summary) and a register field addr[2:0]. Read data appears on rd_data one clock edge after the read strobe and holds until the next read. An unmapped address reads 0.
- R11: With clear-mode 0xF7FFFFFF in the miscellaneous bank, a cause read clears every bit except bit 27. Bit 27 is cleared only by writing a one to it.
- R12: In clear-on-read mode, an event that arrives in the same cycle as a cause read is not returned by that read and stays pending for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Word address: bank field and register field |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rx_evt | input | 32 | Receive bank event inputs |
| tx_evt | input | 32 | Transmit bank event inputs |
| misc_evt | input | 32 | Miscellaneous bank event inputs |
| irq_out | output | 1 | Level interrupt request |

## Verification
Each result has a fixed latency, and every check is timed to it:

| Result | Due |
|---|---|
| Cause and mask registers | at the clock edge that takes the event or write |
| Read data | one edge after the read strobe |
| Summary bit | one edge after the bank becomes pending |
| irq_out | two edges after the event |

The bench drives inputs at the falling edge and samples there too, so each value is read half a period after the edge that produced it. The irq_out latency is checked at the exact cycle: the output must still be low after the first edge and high after the second. Same-cycle collisions are built by driving the event and the clearing access in the same falling-edge slot. These collisions are an event against a write-one-to-clear write, and an event against a clear-on-read read.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_BANKS  = 3;
  localparam int BANK_SEL_W = 2;
  localparam int REG_SEL_W  = 3;
  localparam int ADDR_W     = BANK_SEL_W + REG_SEL_W;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_CAUSE     = 3'd0,
    REG_MASK_SET  = 3'd1,
    REG_MASK_CLR  = 3'd2,
    REG_CAUSE_SET = 3'd3,
    REG_CLR_MODE  = 3'd4,
    REG_MASKED    = 3'd5,
    REG_MASK_VAL  = 3'd6
  } bank_reg_e;

  localparam logic [BANK_SEL_W-1:0] SUM_BANK     = 2'd3;
  localparam logic [REG_SEL_W-1:0]  SUM_REG_CAUSE = 3'd0;
  localparam logic [REG_SEL_W-1:0]  SUM_REG_MASK  = 3'd1;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_cause_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        evt_i,
  input  logic                 sel_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [REG_SEL_W-1:0] reg_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 pend_o
);
  logic [DW-1:0] cause_q, cause_d;
  logic [DW-1:0] mask_q, mask_d;
  logic [DW-1:0] mode_q, mode_d;
  logic          wr_cause, wr_set, wr_mset, wr_mclr, wr_mode, rd_cause;
  logic          cause_en, mask_en;
  logic [DW-1:0] clr_vec, set_vec;

  assign wr_cause = sel_i && wr_i && (reg_i == REG_CAUSE);
  assign wr_set   = sel_i && wr_i && (reg_i == REG_CAUSE_SET);
  assign wr_mset  = sel_i && wr_i && (reg_i == REG_MASK_SET);
  assign wr_mclr  = sel_i && wr_i && (reg_i == REG_MASK_CLR);
  assign wr_mode  = sel_i && wr_i && (reg_i == REG_CLR_MODE);
  assign rd_cause = sel_i && rd_i && (reg_i == REG_CAUSE);

  // Clear sources: read clears only clear-on-read bits that are returned,
  // write clears only write-one-to-clear bits written with 1.
  always_comb begin
    clr_vec = '0;
    if (rd_cause) clr_vec = clr_vec | (cause_q & mode_q);
    if (wr_cause) clr_vec = clr_vec | (wdata_i & ~mode_q);
    set_vec = evt_i;
    if (wr_set) set_vec = set_vec | wdata_i;
  end

  // Set has priority over clear so no event is lost.
  always_comb begin
    cause_d  = (cause_q & ~clr_vec) | set_vec;
    cause_en = (cause_d != cause_q);
  end

  always_comb begin
    mask_d  = mask_q;
    mask_en = wr_mset || wr_mclr;
    if (wr_mset)      mask_d = mask_q | wdata_i;
    else if (wr_mclr) mask_d = mask_q & ~wdata_i;
  end

  assign mode_d = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      if (cause_en) cause_q <= cause_d;
      if (mask_en)  mask_q  <= mask_d;
      if (wr_mode)  mode_q  <= mode_d;
    end
  end

  always_comb begin
    unique case (reg_i)
      REG_CAUSE:    rdata_o = cause_q;
      REG_CLR_MODE: rdata_o = mode_q;
      REG_MASKED:   rdata_o = cause_q & ~mask_q;
      REG_MASK_VAL: rdata_o = mask_q;
      default:      rdata_o = '0;
    endcase
  end

  assign pend_o = |(cause_q & ~mask_q);

  // R1: every event bit is present in the cause register after the edge
  p_evt_captured_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

  // R2: bits written to mask-set are masked afterwards
  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  // R2: bits written to mask-clear are unmasked afterwards
  p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask_q & $past(wdata_i)) == '0));

  // R5: a cause read leaves no returned clear-on-read bit that had no new event
  p_cor_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && !wr_set) |=> ((cause_q & $past(cause_q & mode_q & ~evt_i)) == '0));

  // R4: write-one-to-clear bits survive a cause read
  p_w1c_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cause && !wr_i) |=> ((cause_q & $past(cause_q & ~mode_q)) == $past(cause_q & ~mode_q)));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_cause_pkg::*;
#(
  parameter int NB = NUM_BANKS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0]        pend_i,
  input  logic                 sel_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [REG_SEL_W-1:0] reg_i,
  input  logic [NB-1:0]        wdata_i,
  output logic [NB-1:0]        rdata_o,
  output logic                 irq_o
);
  logic [NB-1:0] sum_q, sum_d;
  logic [NB-1:0] smask_q;
  logic          rd_sum, wr_mask, sum_en;

  assign rd_sum  = sel_i && rd_i && (reg_i == SUM_REG_CAUSE);
  assign wr_mask = sel_i && wr_i && (reg_i == SUM_REG_MASK);

  always_comb begin
    sum_d  = pend_i | (rd_sum ? '0 : sum_q);
    sum_en = (sum_d != sum_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      smask_q <= '1;
    end else begin
      if (sum_en)  sum_q   <= sum_d;
      if (wr_mask) smask_q <= wdata_i;
    end
  end

  always_comb begin
    if (reg_i == SUM_REG_CAUSE)     rdata_o = sum_q;
    else if (reg_i == SUM_REG_MASK) rdata_o = smask_q;
    else                            rdata_o = '0;
  end

  assign irq_o = |(sum_q & ~smask_q);

  // R7: a pending bank shows in the summary at the next edge
  p_sum_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i != '0) |=> ((sum_q & $past(pend_i)) == $past(pend_i)));

  // R7: without a read the summary bits never drop
  p_sum_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sum |=> ((sum_q & $past(sum_q)) == $past(sum_q)));

  // R8: an unmasked pending bank with unchanged mask raises the interrupt next cycle
  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & ~smask_q) != '0 && !wr_mask) |=> irq_o);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     rx_evt,
  input  logic [DW-1:0]     tx_evt,
  input  logic [DW-1:0]     misc_evt,
  output logic              irq_out
);
  localparam int NB = NUM_BANKS;

  logic [BANK_SEL_W-1:0]   bank_sel;
  logic [REG_SEL_W-1:0]    reg_sel;
  logic [NB-1:0][DW-1:0]   evt_bus;
  logic [NB-1:0][DW-1:0]   bank_rdata;
  logic [NB-1:0]           bank_pend;
  logic [NB-1:0]           sum_rdata;
  logic                    sum_sel;
  logic [DW-1:0]           rdata_d, rdata_q;

  assign bank_sel = reg_addr[ADDR_W-1:REG_SEL_W];
  assign reg_sel  = reg_addr[REG_SEL_W-1:0];
  assign evt_bus  = {misc_evt, tx_evt, rx_evt};
  assign sum_sel  = (bank_sel == SUM_BANK);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irq_cause_bank #(.DW(DW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_bus[b]),
      .sel_i   (bank_sel == BANK_SEL_W'(b)),
      .wr_i    (reg_wr),
      .rd_i    (reg_rd),
      .reg_i   (reg_sel),
      .wdata_i (reg_wdata),
      .rdata_o (bank_rdata[b]),
      .pend_o  (bank_pend[b])
    );
  end

  irq_summary #(.NB(NB)) u_summary (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (bank_pend),
    .sel_i   (sum_sel),
    .wr_i    (reg_wr),
    .rd_i    (reg_rd),
    .reg_i   (reg_sel),
    .wdata_i (reg_wdata[NB-1:0]),
    .rdata_o (sum_rdata),
    .irq_o   (irq_out)
  );

  always_comb begin
    rdata_d = '0;
    if (sum_sel) rdata_d = DW'(sum_rdata);
    else if (int'(bank_sel) < NB) rdata_d = bank_rdata[bank_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign rd_data = rdata_q;

  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(rd_data));

  // R9: interrupt output low while everything is masked out of reset
  p_irq_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !irq_out);
endmodule

// File: tb/irq_cause_ctrl_tb.sv
module irq_cause_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, rd_data;
  logic [31:0] rx_evt, tx_evt, misc_evt;
  logic        irq_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .rx_evt(rx_evt), .tx_evt(tx_evt), .misc_evt(misc_evt), .irq_out(irq_out)
  );

  function automatic logic [4:0] ad(input int bank, input int rg);
    return 5'(bank * 8 + rg);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input int bank, input logic [31:0] v);
    @(negedge clk);
    if (bank == 0) rx_evt = v; else if (bank == 1) tx_evt = v; else misc_evt = v;
    @(negedge clk);
    rx_evt = '0; tx_evt = '0; misc_evt = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R9 irq after reset", 32'(irq_out), 32'h0);
    rd(ad(0,0), d); check("R9 rx cause", d, 32'h0);
    rd(ad(2,6), d); check("R9 misc mask", d, 32'hFFFF_FFFF);
    rd(ad(1,4), d); check("R9 tx clear mode", d, 32'h0);
    rd(ad(3,1), d); check("R9 summary mask", d, 32'h7);
  endtask

  task automatic t_tx_mask_w1c;
    logic [31:0] d;
    pulse(1, 32'h0100_0001);
    rd(ad(1,0), d); check("R1 tx cause", d, 32'h0100_0001);
    rd(ad(1,5), d); check("R3 masked view all masked", d, 32'h0);
    wr(ad(1,2), 32'h0000_0001);
    rd(ad(1,6), d); check("R2 mask clear", d, 32'hFFFF_FFFE);
    rd(ad(1,5), d); check("R3 masked view", d, 32'h0000_0001);
    check("R8 irq masked at summary", 32'(irq_out), 32'h0);
    wr(ad(3,1), 32'h0);
    check("R8 irq after summary unmask", 32'(irq_out), 32'h1);
    rd(ad(3,0), d); check("R7 summary tx bit", d, 32'h2);
    wr(ad(1,0), 32'h0000_0001);
    rd(ad(1,0), d); check("R4 w1c clears written bit only", d, 32'h0100_0000);
    rd(ad(3,0), d); check("R7 summary sticky", d, 32'h2);
    rd(ad(3,0), d); check("R7 summary cleared by read", d, 32'h0);
    check("R8 irq low when summary empty", 32'(irq_out), 32'h0);
    wr(ad(1,1), 32'h0000_0001);
    rd(ad(1,6), d); check("R2 mask set", d, 32'hFFFF_FFFF);
    wr(ad(1,0), 32'h0100_0000);
    rd(ad(1,0), d); check("R4 tx cause empty", d, 32'h0);
  endtask

  task automatic t_rx_cor;
    logic [31:0] d;
    wr(ad(0,4), 32'hFFFF_FFFF);
    rd(ad(0,4), d); check("R5 clear mode readback", d, 32'hFFFF_FFFF);
    pulse(0, 32'h0000_00A5);
    rd(ad(0,0), d); check("R5 cor read value", d, 32'h0000_00A5);
    rd(ad(0,0), d); check("R5 cor cleared", d, 32'h0);
  endtask

  task automatic t_misc_mixed;
    logic [31:0] d;
    wr(ad(2,4), 32'hF7FF_FFFF);
    pulse(2, 32'h0800_0010);
    rd(ad(2,0), d); check("R11 misc first read", d, 32'h0800_0010);
    rd(ad(2,0), d); check("R11 bit27 survives read", d, 32'h0800_0000);
    wr(ad(2,0), 32'h0800_0000);
    rd(ad(2,0), d); check("R11 bit27 w1c", d, 32'h0);
    wr(ad(2,3), 32'h0800_0000);
    rd(ad(2,0), d); check("R6 cause set", d, 32'h0800_0000);
    wr(ad(2,0), 32'h0800_0000);
    pulse(2, 32'h0000_0010);
    wr(ad(2,0), 32'h0000_0010);
    rd(ad(2,0), d); check("R4 write ignored on cor bit", d, 32'h0000_0010);
    rd(ad(2,0), d); check("R5 misc empty", d, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(ad(0,4), 32'h0);
    pulse(0, 32'h0000_0008);
    @(negedge clk);
    reg_addr = ad(0,0); reg_wdata = 32'h8; reg_wr = 1'b1; rx_evt = 32'h8;
    @(negedge clk);
    reg_wr = 1'b0; rx_evt = '0;
    rd(ad(0,0), d); check("R1 set wins over w1c", d, 32'h0000_0008);
    wr(ad(0,0), 32'h8);
    rd(ad(0,0), d); check("R1 cleared afterwards", d, 32'h0);
  endtask

  task automatic t_cor_race;
    logic [31:0] d;
    wr(ad(0,4), 32'hFFFF_FFFF);
    pulse(0, 32'h0000_0001);
    @(negedge clk);
    reg_addr = ad(0,0); reg_rd = 1'b1; rx_evt = 32'h2;
    @(negedge clk);
    reg_rd = 1'b0; rx_evt = '0;
    check("R12 read returns old value", rd_data, 32'h0000_0001);
    rd(ad(0,0), d); check("R12 new event kept", d, 32'h0000_0002);
    rd(ad(0,0), d); check("R12 empty", d, 32'h0);
  endtask

  task automatic t_irq_timing;
    logic [31:0] d;
    wr(ad(0,2), 32'h0000_0010);
    @(negedge clk);
    rx_evt = 32'h10;
    @(negedge clk);
    rx_evt = '0;
    check("R8 irq not yet after first edge", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R8 irq after second edge", 32'(irq_out), 32'h1);
    rd(ad(0,0), d); check("R8 rx cause", d, 32'h10);
    rd(ad(3,0), d); check("R7 summary rx bit", d, 32'h1);
    check("R8 irq released", 32'(irq_out), 32'h0);
    wr(ad(0,1), 32'h0000_0010);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(ad(3,5), d); check("R10 unmapped summary reg", d, 32'h0);
    rd(ad(1,7), d); check("R10 unmapped bank reg", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_evt = '0; tx_evt = '0; misc_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_mask_w1c();
    t_rx_cor();
    t_misc_mixed();
    t_set_wins();
    t_cor_race();
    t_irq_timing();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule